// File: doc/BRIEF.md
# Sigma-Delta Front End with Integrate-and-Dump Decimator

This block is the digital side of a first-order sigma-delta converter. The analog side is a differential input used as a comparator, plus an external resistor-capacitor integrator. For each channel, the block passes the comparator output through two flops and drives the resulting bit back out as the feedback level. That feedback closes the loop through the external integrator.

The same synchronized bit feeds a per-channel ones counter. The counter runs over a fixed window of modulator clocks. At the end of each window the block latches every channel's total and raises a single valid strobe for all channels. The counter then restarts without dropping a sample. With a window of about 32768 clocks and a modulator clock of up to 33 MHz, one result appears roughly every millisecond.

A separate free-running square wave with exactly 50 percent duty is also provided. After external RC filtering it becomes a mid-scale reference shared by all channels.

Top module: `sdm_front_end`

## Requirements
- R1: Feedback latency. After any clock edge, `fb_o[c]` equals the value `cmp_i[c]` had at the previous edge. The result is two flops of latency from the pin, and `fb_o` is 0 until two edges after reset.
- R2: Window sum. Window j covers clock edges (j-1)*WIN_LEN+1 through j*WIN_LEN after reset. Its result is the number of ones the synchronized bit carried into those edges. The bit counted at edge e is `cmp_i` as sampled at edge e-2, and it is 0 for e <= 2. Every edge belongs to exactly one window, so no bit is lost or counted twice at a boundary.
- R3: Saturation. A window total above 2^CNT_W-1 is reported as 2^CNT_W-1 and never wraps.
- R4: Valid cadence. `valid_o` is high for exactly one cycle after edge j*WIN_LEN for every j >= 1, and low at all other times. The first pulse comes one full window after reset.
- R5: Hold. `result_o` changes only together with a `valid_o` pulse, and keeps its value between pulses.
- R6: Reference. `ref_o` is low out of reset and toggles after every REF_HALF edges. After edge m it equals bit 0 of m/REF_HALF, which gives equal high and low times.
- R7: Reset. Reset is active-low and asynchronous. While `rst_ni` is low, `fb_o`, `ref_o`, `valid_o` and `result_o` are all 0, immediately and regardless of the clock. A reset in the middle of a window discards the partial sum.
- R8: Channel packing. Channel c reports in `result_o[c*CNT_W +: CNT_W]`. All channels share one window boundary and one `valid_o`, and each channel's count depends only on its own `cmp_i[c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | NUM_CH | Comparator outputs, one per channel |
| fb_o | output | NUM_CH | Registered feedback bits to the external integrators |
| ref_o | output | 1 | 50 percent duty square wave for the shared reference |
| result_o | output | NUM_CH*CNT_W | Packed per-channel window totals |
| valid_o | output | 1 | One-cycle strobe marking new totals |

## Verification
The bound checker watches five properties on every cycle:
- the two-edge feedback latency;
- the valid cadence, counted against its own window counter;
- that results hold between strobes;
- the saturation ceiling on each lane;
- the exact half-period of the reference.

Only the bench scenarios can show that the reported totals are the correct sums. They drive zero, full, alternating, scrambled and ramped-density bitstreams, with a different stream on each lane, and compare every total with a sum computed from the recorded inputs. They also check that the partial first window accounts for the synchronizer fill. An asynchronous reset in the middle of a window, followed by a clean restart, is likewise covered only by the bench.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  // bits to hold values 0..n-1, never zero
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sdm_sync.sv
module sdm_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdm_window.sv
module sdm_window import sdm_pkg::*; #(
  parameter int unsigned WIN_LEN = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic last_o,
  output logic valid_o
);
  localparam int unsigned WC_W = idx_w(WIN_LEN);

  logic [WC_W-1:0] wcnt_q;
  logic            valid_q;

  assign last_o = (wcnt_q == WC_W'(WIN_LEN-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      wcnt_q  <= last_o ? '0 : wcnt_q + 1'b1;
      valid_q <= last_o;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/sdm_accum.sv
module sdm_accum import sdm_pkg::*; #(
  parameter int unsigned WIN_LEN = 32768,
  parameter int unsigned CNT_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             last_i,
  output logic [CNT_W-1:0] res_o
);
  localparam int unsigned ACC_W = idx_w(WIN_LEN + 1);
  localparam int unsigned SUM_W = (ACC_W > CNT_W) ? ACC_W : CNT_W;
  localparam logic [SUM_W-1:0] LIM = SUM_W'({CNT_W{1'b1}});

  logic [SUM_W-1:0] acc_q, sum;
  logic [CNT_W-1:0] res_q;

  // the bit of the closing edge belongs to the closing window
  assign sum = acc_q + SUM_W'(bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_q <= '0;
    end else if (last_i) begin
      res_q <= (sum > LIM) ? CNT_W'(LIM) : CNT_W'(sum);
      acc_q <= '0;
    end else begin
      acc_q <= sum;
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/sdm_ref_gen.sv
module sdm_ref_gen import sdm_pkg::*; #(
  parameter int unsigned REF_HALF = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ref_o
);
  localparam int unsigned HC_W = idx_w(REF_HALF);

  logic [HC_W-1:0] hc_q;
  logic            lvl_q;
  logic            flip;

  assign flip = (hc_q == HC_W'(REF_HALF-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q  <= '0;
      lvl_q <= 1'b0;
    end else begin
      hc_q  <= flip ? '0 : hc_q + 1'b1;
      lvl_q <= lvl_q ^ flip;
    end
  end

  assign ref_o = lvl_q;
endmodule

// File: rtl/sdm_front_end.sv
module sdm_front_end import sdm_pkg::*; #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned WIN_LEN  = 32768,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned REF_HALF = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       cmp_i,
  output logic [NUM_CH-1:0]       fb_o,
  output logic                    ref_o,
  output logic [NUM_CH*CNT_W-1:0] result_o,
  output logic                    valid_o
);
  logic [NUM_CH-1:0] bit_s;
  logic              last;

  sdm_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i, .rst_ni, .d_i(cmp_i), .q_o(bit_s)
  );

  // last sync flop is the feedback register
  assign fb_o = bit_s;

  sdm_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk_i, .rst_ni, .last_o(last), .valid_o(valid_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sdm_accum #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_acc (
      .clk_i, .rst_ni,
      .bit_i (bit_s[c]),
      .last_i(last),
      .res_o (result_o[c*CNT_W +: CNT_W])
    );
  end

  sdm_ref_gen #(.REF_HALF(REF_HALF)) u_ref (
    .clk_i, .rst_ni, .ref_o(ref_o)
  );
endmodule

// File: rtl/sdm_front_end_chk.sv
module sdm_front_end_chk import sdm_pkg::*; #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned WIN_LEN  = 32768,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned REF_HALF = 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_CH-1:0]       cmp_i,
  input logic [NUM_CH-1:0]       fb_o,
  input logic                    ref_o,
  input logic [NUM_CH*CNT_W-1:0] result_o,
  input logic                    valid_o
);
  localparam int unsigned WC_W = idx_w(WIN_LEN);
  localparam int unsigned RC_W = idx_w(REF_HALF + 1) + 1;
  localparam longint unsigned CMAX = (64'd1 << CNT_W) - 1;
  localparam longint unsigned LIM  = (WIN_LEN < CMAX) ? WIN_LEN : CMAX;

  logic [1:0]      cyc_q;
  logic [WC_W-1:0] vc_q;
  logic            seen_q;
  logic            ref_q;
  logic [RC_W-1:0] rc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      vc_q   <= '0;
      seen_q <= 1'b0;
      ref_q  <= 1'b0;
      rc_q   <= '0;
    end else begin
      cyc_q  <= (cyc_q == 2'd3) ? cyc_q : cyc_q + 1'b1;
      vc_q   <= (vc_q == WC_W'(WIN_LEN-1)) ? '0 : vc_q + 1'b1;
      seen_q <= 1'b1;
      ref_q  <= ref_o;
      rc_q   <= (ref_o != ref_q) ? RC_W'(1) : rc_q + 1'b1;
    end
  end

  // R1: feedback lags the pin by two edges
  p_fb_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (fb_o == $past(cmp_i, 2)));

  p_valid_cadence_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (seen_q && vc_q == '0));

  p_result_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));

  p_ref_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_o != ref_q) |-> (rc_q == RC_W'(REF_HALF)));

  p_ref_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_q <= RC_W'(REF_HALF));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      64'(result_o[c*CNT_W +: CNT_W]) <= LIM);
  end
endmodule

bind sdm_front_end sdm_front_end_chk #(
  .NUM_CH(NUM_CH), .WIN_LEN(WIN_LEN), .CNT_W(CNT_W), .REF_HALF(REF_HALF)
) u_chk (.*);

// File: tb/tb_sdm_front_end.sv
module tb_sdm_front_end;
  localparam int NCH = 3;
  localparam int W   = 16;
  localparam int CW  = 4;
  localparam int H   = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]    cmp = '0;
  logic [NCH-1:0]    fb;
  logic              rf;
  logic [NCH*CW-1:0] res;
  logic              vld;

  int vectors = 0;
  int errs = 0;
  bit hist [0:255][0:NCH-1];
  int last_exp [NCH];

  always #5 clk = ~clk;

  sdm_front_end #(.NUM_CH(NCH), .WIN_LEN(W), .CNT_W(CW), .REF_HALF(H)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .fb_o(fb), .ref_o(rf),
    .result_o(res), .valid_o(vld)
  );

  task automatic chk(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d @%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pat(int mode, int e, int c);
    case (mode)
      0: return 1'b0;
      1: return 1'b1;
      2: return bit'((e + c) % 2);
      3: return ((e * 5 + c * 3 + (e >> 3)) % 7) < 3;
      default: return (e % W) < ((e / W + c) % (W + 1));
    endcase
  endfunction

  function automatic bit sbit(int e, int c);
    return (e >= 3) ? hist[e-2][c] : 1'b0;
  endfunction

  task automatic check_edge(int m);
    chk("R4 valid", vld, (m % W == 0));
    chk("R6 ref", rf, (m / H) % 2);
    for (int c = 0; c < NCH; c++) begin
      chk("R1 feedback", fb[c], (m >= 2) ? hist[m-1][c] : 0);
      if (m % W == 0) begin
        int s = 0;
        for (int e = m - W + 1; e <= m; e++) s += sbit(e, c);
        last_exp[c] = (s > CMAX) ? CMAX : s;
        if (s > CMAX) chk("R3 saturate", res[c*CW +: CW], CMAX);
      end
      // R2 sums, R5 hold, R8 lane packing
      chk("R2/R5/R8 result", res[c*CW +: CW], last_exp[c]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R7 async fb", fb, 0);
    chk("R7 async ref", rf, 0);
    chk("R7 async valid", vld, 0);
    chk("R7 async result", res, 0);
    cmp = '1;
    repeat (2) @(negedge clk);
    chk("R7 held result", res, 0);
    chk("R7 held fb", fb, 0);
    for (int e = 0; e < 256; e++)
      for (int c = 0; c < NCH; c++) hist[e][c] = 1'b0;
    for (int c = 0; c < NCH; c++) last_exp[c] = 0;
    rst_n = 1'b1;
  endtask

  task automatic run_phase(int mode, int nedges);
    do_reset();
    for (int c = 0; c < NCH; c++) begin
      hist[1][c] = pat(mode, 1, c);
      cmp[c] = hist[1][c];
    end
    for (int m = 1; m <= nedges; m++) begin
      @(negedge clk);
      check_edge(m);
      for (int c = 0; c < NCH; c++) begin
        hist[m+1][c] = pat(mode, m + 1, c);
        cmp[c] = hist[m+1][c];
      end
    end
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    run_phase(0, 100);  // R2 all zero
    run_phase(1, 100);  // R3 all ones saturate
    run_phase(2, 100);  // R2/R8 alternating, lanes opposite
    run_phase(3, 100);  // R2 scrambled
    run_phase(4, 120);  // R2 density ramp per lane
    run_phase(3, 40);   // R7 then reset mid-window
    run_phase(1, 50);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule